// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This block holds the program counter of a small microcontroller core and chooses its next value once per instruction cycle. It selects one of several sources on each advance strobe. The sources are a plain increment, a skip of one instruction, a short jump that replaces only the low byte and stays inside the current 256-word page, a full jump or call to an address from the instruction, a return to an address popped from a hardware stack, and fixed vectors for reset and three interrupt causes.

A request to restart has the highest priority. An accepted interrupt comes next, and the execute-stage source code comes last. On a call or an interrupt entry, the block also presents the address of the next sequential instruction and a push strobe, so that an external stack can save it. The low byte of the counter can be read through a small register read port.

Top module: `pc_next_unit`

## Requirements
- R1: While `rst_n` is low, `pc` is 0x0000 and `push_en` is low.
- R2: On a clock edge where `adv` and `rst_req` are both low, `pc` keeps its value.
- R3: With `adv` high and no reset or interrupt request, a `src_sel` of 0 (increment), 6 or 7 loads `pc`+1 modulo 2^13. The value 0x1FFF wraps to 0x0000.
- R4: `src_sel` = 1 (skip) loads `pc`+2 modulo 2^13.
- R5: `src_sel` = 2 (low-byte write) loads {`pc`[12:8], `lb_wdata`}, so the page bits stay unchanged.
- R6: `src_sel` = 3 (jump) loads `tgt`[12:0].
- R7: `src_sel` = 4 (call) loads `tgt`. In that same cycle `push_en` is high and `push_addr` equals `pc`+1.
- R8: `src_sel` = 5 (return) loads `ret_addr`.
- R9: With `adv` high, `irq_req` high and no reset request, `pc` loads the vector (`irq_sel`+1)×4. That gives 0x004 for `irq_sel` 0 (external), 0x008 for 1 (timer 0), 0x00C for 2 (timer 1) and 0x010 for 3. `push_en` is high in that cycle and `push_addr` equals `pc`+1.
- R10: `rst_req` high loads 0x000 on the next edge whether or not `adv` is high, and it overrides both an interrupt and the source code. `push_en` stays low while `rst_req` is high.
- R11: An accepted interrupt overrides `src_sel`.
- R12: `rd_data` equals `pc`[7:0] when `rd_addr` is 0x06, and 0x00 for any other address.
- R13: `push_en` is low whenever no call or interrupt is being taken on an advance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adv | input | 1 | Instruction-cycle advance strobe |
| rst_req | input | 1 | Synchronous restart request |
| irq_req | input | 1 | Interrupt entry accepted this cycle |
| irq_sel | input | 2 | Interrupt cause index |
| src_sel | input | 3 | Execute-stage source code |
| tgt | input | 13 | Jump or call target from the instruction |
| lb_wdata | input | 8 | Value written to the low byte |
| ret_addr | input | 13 | Address popped from the stack |
| rd_addr | input | 8 | Register read address |
| pc | output | 13 | Current program counter |
| rd_data | output | 8 | Register read data |
| push_addr | output | 13 | Address to push on call or interrupt |
| push_en | output | 1 | Push strobe |

## Verification
The bench builds the block with its default widths: a 13-bit counter, an 8-bit low byte and a vector stride of 4. With these widths, the wrap from 0x1FFF to 0x0000 under both increment and skip can be reached in a few cycles by jumping near the top first. The page-keeping rule of the low-byte write can be seen in the upper five bits.

Randomised cycles mix every source code, interrupt cause, reset request and idle cycle, and a behavioural model predicts `pc`, the push outputs and the read port on every clock.

// File: rtl/pcnu_pkg.sv
package pcnu_pkg;

    typedef enum logic [2:0] {
        SRC_INC  = 3'd0,
        SRC_SKIP = 3'd1,
        SRC_LBW  = 3'd2,
        SRC_JMP  = 3'd3,
        SRC_CALL = 3'd4,
        SRC_RET  = 3'd5,
        SRC_RSV6 = 3'd6,
        SRC_RSV7 = 3'd7
    } src_e;

endpackage

// File: rtl/pcnu_vec_gen.sv
module pcnu_vec_gen #(
    parameter int PC_W      = 13,
    parameter int SEL_W     = 2,
    parameter int STRIDE_SH = 2
) (
    input  logic [SEL_W-1:0] irq_sel,
    output logic [PC_W-1:0]  vec
);
    logic [PC_W-1:0] idx;

    always_comb begin
        idx = PC_W'(irq_sel) + PC_W'(1);
        vec = idx << STRIDE_SH;
    end
endmodule

// File: rtl/pcnu_src_mux.sv
module pcnu_src_mux
    import pcnu_pkg::*;
#(
    parameter int PC_W = 13,
    parameter int LB_W = 8
) (
    input  logic [PC_W-1:0] pc_cur,
    input  logic [2:0]      src_sel,
    input  logic [PC_W-1:0] tgt,
    input  logic [LB_W-1:0] lb_wdata,
    input  logic [PC_W-1:0] ret_addr,
    output logic [PC_W-1:0] pc_exe,
    output logic            is_call
);
    src_e src;

    always_comb begin
        src     = src_e'(src_sel);
        is_call = 1'b0;
        unique case (src)
            SRC_SKIP: pc_exe = pc_cur + PC_W'(2);
            SRC_LBW:  pc_exe = {pc_cur[PC_W-1:LB_W], lb_wdata};
            SRC_JMP:  pc_exe = tgt;
            SRC_CALL: begin
                pc_exe  = tgt;
                is_call = 1'b1;
            end
            SRC_RET:  pc_exe = ret_addr;
            default:  pc_exe = pc_cur + PC_W'(1);
        endcase
    end
endmodule

// File: rtl/pc_next_unit.sv
module pc_next_unit #(
    parameter int       PC_W      = 13,
    parameter int       LB_W      = 8,
    parameter int       SEL_W     = 2,
    parameter int       STRIDE_SH = 2,
    parameter int       RA_W      = 8,
    parameter bit [7:0] PCL_ADDR  = 8'h06
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             rst_req,
    input  logic             irq_req,
    input  logic [SEL_W-1:0] irq_sel,
    input  logic [2:0]       src_sel,
    input  logic [PC_W-1:0]  tgt,
    input  logic [LB_W-1:0]  lb_wdata,
    input  logic [PC_W-1:0]  ret_addr,
    input  logic [RA_W-1:0]  rd_addr,
    output logic [PC_W-1:0]  pc,
    output logic [LB_W-1:0]  rd_data,
    output logic [PC_W-1:0]  push_addr,
    output logic             push_en
);
    localparam logic [PC_W-1:0] RESET_VEC = '0;

    typedef struct packed {
        logic [PC_W-1:0] pc;
    } state_t;

    state_t          st_d, st_q;
    logic [PC_W-1:0] vec;
    logic [PC_W-1:0] pc_exe;
    logic            is_call;

    pcnu_vec_gen #(.PC_W(PC_W), .SEL_W(SEL_W), .STRIDE_SH(STRIDE_SH)) u_vec (
        .irq_sel (irq_sel),
        .vec     (vec)
    );

    pcnu_src_mux #(.PC_W(PC_W), .LB_W(LB_W)) u_mux (
        .pc_cur   (st_q.pc),
        .src_sel  (src_sel),
        .tgt      (tgt),
        .lb_wdata (lb_wdata),
        .ret_addr (ret_addr),
        .pc_exe   (pc_exe),
        .is_call  (is_call)
    );

    always_comb begin
        st_d      = st_q;
        push_en   = 1'b0;
        push_addr = st_q.pc + PC_W'(1);
        if (rst_req) begin
            st_d.pc = RESET_VEC;
        end else if (adv) begin
            if (irq_req) begin
                st_d.pc = vec;
                push_en = 1'b1;
            end else begin
                st_d.pc = pc_exe;
                push_en = is_call;
            end
        end
        pc      = st_q.pc;
        rd_data = (rd_addr == RA_W'(PCL_ADDR)) ? st_q.pc[LB_W-1:0] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{pc: RESET_VEC};
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pcnu_checker.sv
module pcnu_checker #(
    parameter int PC_W  = 13,
    parameter int LB_W  = 8,
    parameter int SEL_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             adv,
    input logic             rst_req,
    input logic             irq_req,
    input logic [2:0]       src_sel,
    input logic [PC_W-1:0]  tgt,
    input logic [PC_W-1:0]  ret_addr,
    input logic [LB_W-1:0]  lb_wdata,
    input logic [PC_W-1:0]  pc,
    input logic [PC_W-1:0]  push_addr,
    input logic             push_en
);
    logic exe_ok;
    assign exe_ok = adv && !rst_req && !irq_req;

    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !rst_req) |=> $stable(pc)); // R2
    AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> (pc == '0)); // R10
    AST_RST_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> !push_en); // R10
    AST_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (exe_ok && src_sel == 3'd0) |=> (pc == $past(pc) + PC_W'(1))); // R3
    AST_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (exe_ok && src_sel == 3'd1) |=> (pc == $past(pc) + PC_W'(2))); // R4
    AST_PAGE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (exe_ok && src_sel == 3'd2) |=>
        (pc[PC_W-1:LB_W] == $past(pc[PC_W-1:LB_W]) && pc[LB_W-1:0] == $past(lb_wdata))); // R5
    AST_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
        (exe_ok && src_sel == 3'd3) |=> (pc == $past(tgt))); // R6
    AST_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (exe_ok && src_sel == 3'd5) |=> (pc == $past(ret_addr))); // R8
    AST_VEC_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !rst_req && irq_req) |=> (pc[1:0] == 2'b00 && pc != '0)); // R9
    AST_PUSH_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        push_en |=> ($past(push_addr) == $past(pc) + PC_W'(1))); // R7
    AST_PUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv) |-> !push_en); // R13
endmodule

bind pc_next_unit pcnu_checker #(.PC_W(PC_W), .LB_W(LB_W), .SEL_W(SEL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv       (adv),
    .rst_req   (rst_req),
    .irq_req   (irq_req),
    .src_sel   (src_sel),
    .tgt       (tgt),
    .ret_addr  (ret_addr),
    .lb_wdata  (lb_wdata),
    .pc        (pc),
    .push_addr (push_addr),
    .push_en   (push_en)
);

// File: tb/sim_pc_next_unit.sv
`timescale 1ns/1ps
module sim_pc_next_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        adv = 1'b0, rst_req = 1'b0, irq_req = 1'b0;
    logic [1:0]  irq_sel = '0;
    logic [2:0]  src_sel = '0;
    logic [12:0] tgt = '0, ret_addr = '0;
    logic [7:0]  lb_wdata = '0, rd_addr = '0;
    logic [12:0] pc, push_addr;
    logic [7:0]  rd_data;
    logic        push_en;

    int checks = 0, failures = 0;
    int m_pc = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pc_next_unit u0 (
        .clk(clk), .rst_n(rst_n), .adv(adv), .rst_req(rst_req), .irq_req(irq_req),
        .irq_sel(irq_sel), .src_sel(src_sel), .tgt(tgt), .lb_wdata(lb_wdata),
        .ret_addr(ret_addr), .rd_addr(rd_addr), .pc(pc), .rd_data(rd_data),
        .push_addr(push_addr), .push_en(push_en)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic string tag_of(input bit a, input bit r, input bit q, input int s);
        if (r) return "R10";
        if (!a) return "R2";
        if (q) return "R9/R11";
        case (s)
            1: return "R4";
            2: return "R5";
            3: return "R6";
            4: return "R7";
            5: return "R8";
            default: return "R3";
        endcase
    endfunction

    // One cycle: drive after the falling edge, check outputs, then check the new pc after the rising edge
    task automatic step(input bit a, input bit r, input bit q, input int qs, input int s,
                        input int t, input int lb, input int ra, input int rda);
        int exp_next, exp_push;
        string tg;
        @(negedge clk);
        adv = a; rst_req = r; irq_req = q; irq_sel = 2'(qs); src_sel = 3'(s);
        tgt = 13'(t); lb_wdata = 8'(lb); ret_addr = 13'(ra); rd_addr = 8'(rda);
        #1;
        exp_push = (!r && a && (q || s == 4)) ? 1 : 0;
        chk(exp_push ? "R7/R9 push_en" : "R13 push_en", int'(push_en), exp_push);
        if (exp_push) chk("R7/R9 push_addr", int'(push_addr), (m_pc + 1) % 8192);
        chk("R12 rd_data", int'(rd_data), (rda == 6) ? (m_pc % 256) : 0);
        if (r)           exp_next = 0;
        else if (!a)     exp_next = m_pc;
        else if (q)      exp_next = (qs + 1) * 4;
        else case (s)
            1: exp_next = (m_pc + 2) % 8192;
            2: exp_next = (m_pc / 256) * 256 + lb;
            3, 4: exp_next = t % 8192;
            5: exp_next = ra % 8192;
            default: exp_next = (m_pc + 1) % 8192;
        endcase
        tg = tag_of(a, r, q, s);
        @(posedge clk);
        m_pc = exp_next;
        #1;
        chk(tg, int'(pc), m_pc);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            failures++; checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #12;
        chk("R1 pc", int'(pc), 0);
        chk("R1 push_en", int'(push_en), 0);
        @(negedge clk);
        rst_n = 1'b1;
        // R3 increment, reserved codes
        step(1, 0, 0, 0, 0, 0, 0, 0, 6);
        step(1, 0, 0, 0, 6, 0, 0, 0, 6);
        step(1, 0, 0, 0, 7, 0, 0, 0, 6);
        // R2 hold
        step(0, 0, 0, 0, 3, 13'h1555, 0, 0, 6);
        // R6 jump near top, R3 wrap
        step(1, 0, 0, 0, 3, 13'h1FFF, 0, 0, 6);
        step(1, 0, 0, 0, 0, 0, 0, 0, 6);
        // R4 skip wrap
        step(1, 0, 0, 0, 3, 13'h1FFE, 0, 0, 0);
        step(1, 0, 0, 0, 1, 0, 0, 0, 6);
        // R5 low-byte write keeps page
        step(1, 0, 0, 0, 3, 13'h1A77, 0, 0, 6);
        step(1, 0, 0, 0, 2, 0, 8'h34, 0, 6);
        // R7 call, R8 return
        step(1, 0, 0, 0, 4, 13'h0ABC, 0, 0, 6);
        step(1, 0, 0, 0, 5, 0, 0, 13'h1A35, 6);
        // R9 each vector, R11 over source
        for (int i = 0; i < 4; i++) step(1, 0, 1, i, 3, 13'h1111, 0, 0, 6);
        // R10 restart with and without adv, over irq
        step(1, 0, 0, 0, 3, 13'h0F00, 0, 0, 6);
        step(0, 1, 0, 0, 0, 0, 0, 0, 6);
        step(1, 0, 0, 0, 3, 13'h0F00, 0, 0, 6);
        step(1, 1, 1, 2, 4, 13'h0123, 0, 0, 6);
        // randomised mix
        for (int i = 0; i < 3000; i++)
            step(($urandom % 5) != 0, ($urandom % 23) == 0, ($urandom % 7) == 0,
                 $urandom % 4, $urandom % 8, $urandom % 8192, $urandom % 256,
                 $urandom % 8192, (($urandom % 2) != 0) ? 6 : ($urandom % 256));
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule